// File: doc/BRIEF.md
# Prioritized Pending Source Resolver

This block picks, from up to 40 interrupt sources, the most urgent active one in each of two delivery classes: the fast class and the normal class. Each cycle it can accept one snapshot made of the per-source pending, enable and class vectors and a 40-slot priority table. Each table slot names one source. A slot with a lower index is more urgent than a slot with a higher index. The block returns one 32-bit status word. The fast-class winner goes in the low half of that word and the normal-class winner goes in the high half.

Snapshots enter through a valid/ready input port and results leave through a valid/ready output port. A snapshot is taken on a rising edge where `in_valid` and `in_ready` are both high. Its word is offered on `out_valid` and is held there until it is taken on an edge where `out_ready` is high. Results leave in the order the snapshots arrived. While `out_valid` is high and `out_ready` is low, the word is held and the two pipeline stages fill. Once both stages hold data, `in_ready` drops. The registers that store the table and the vectors, and the bus decode in front of them, are outside this block.

Top module: `prio_resolver`

## Requirements
- R1: A table slot takes part only when bit 31 of its 32-bit entry is 1 and its source number, in bits 5:0, is below 40. All other entry bits are ignored.
- R2: A source is active only when its bit in `src_pend` and its bit in `src_en` are both 1. Its `src_fast` bit selects the class: 1 means the fast class and 0 means the normal class.
- R3: Among the taking-part slots whose source is active in a class, the slot with the lowest index wins. Two slots may name the same source without any error.
- R4: Fast-class result: `status` bit 15 is 1 when there is a winner, and bits 5:0 hold the winner's source number.
- R5: Normal-class result: `status` bit 31 is 1 when there is a winner, and bits 21:16 hold the winner's source number.
- R6: A class with no winner reads with its flag at 0 and its ID field at 63. With no winner in either class, the word is 0x003F003F.
- R7: The two classes are searched independently, so both flags can be 1 in the same word.
- R8: `status` bits 30:22 and 14:6 are always 0.
- R9: With `out_ready` held high, a snapshot accepted on edge N is offered with `out_valid` high after edge N+1. Words leave in acceptance order, and none is lost or duplicated.
- R10: While `out_valid` is 1 and `out_ready` is 0, `status` stays unchanged. Whenever `out_ready` is 1, `in_ready` is 1.
- R11: During and after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A snapshot is offered |
| in_ready | output | 1 | The block can take a snapshot |
| src_pend | input | 40 | Pending bit per source |
| src_en | input | 40 | Enable bit per source |
| src_fast | input | 40 | Class bit per source (1 = fast class) |
| prio_tbl | input | 1280 | 40 entries of 32 bits; slot k occupies bits 32k+31:32k |
| out_valid | output | 1 | A status word is offered |
| out_ready | input | 1 | The consumer takes the word |
| status | output | 32 | Packed fast-class and normal-class result |

## Verification
The fast-class search and the normal-class search fall into the same word. The bench provokes this by giving class-mixed active sources to tables that have junk bits and duplicate slots. It then judges both halves against a scan model that walks the slots in order. Acceptance of a new snapshot and the stall of an older one also coincide: a random `out_ready` pattern makes the pipeline hold a word while another is entering. The word must stay stable, and the results must leave in the order of the scoreboard.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int ENTRY_W   = 32;
  localparam int ID_W      = 6;
  localparam int EN_BIT    = 31;
  localparam logic [ID_W-1:0] NONE_ID = '1;
  localparam int FAST_FLAG = 15;
  localparam int NORM_FLAG = 31;
  localparam int NORM_LSB  = 16;

  typedef struct packed {
    logic            found;
    logic [ID_W-1:0] id;
  } pick_t;

  function automatic logic [31:0] pack_word(pick_t fast_p, pick_t norm_p);
    logic [31:0] w;
    w = '0;
    w[FAST_FLAG]                 = fast_p.found;
    w[ID_W-1:0]                  = fast_p.found ? fast_p.id : NONE_ID;
    w[NORM_FLAG]                 = norm_p.found;
    w[NORM_LSB +: ID_W]          = norm_p.found ? norm_p.id : NONE_ID;
    return w;
  endfunction
endpackage

// File: rtl/prs_slot_qualify.sv
module prs_slot_qualify
  import prs_pkg::*;
#(
  parameter int NSRC  = 40,
  parameter int NSLOT = 40
) (
  input  logic [NSRC-1:0]          pend,
  input  logic [NSRC-1:0]          en,
  input  logic [NSRC-1:0]          fast,
  input  logic [NSLOT*ENTRY_W-1:0] tbl,
  output logic [NSLOT-1:0]         hit_fast,
  output logic [NSLOT-1:0]         hit_norm,
  output logic [NSLOT*ID_W-1:0]    ids
);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] active;
  assign active = pend & en;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic [ENTRY_W-1:0] entry;
    logic [ID_W-1:0]    num;
    logic               in_range;
    logic               usable;
    logic [SW-1:0]      sel;
    logic               src_act;
    logic               src_fast;

    assign entry    = tbl[k*ENTRY_W +: ENTRY_W];
    assign num      = entry[ID_W-1:0];
    assign in_range = ({26'd0, num} < NSRC);
    assign usable   = entry[EN_BIT] && in_range;
    assign sel      = in_range ? num[SW-1:0] : '0;
    assign src_act  = active[sel];
    assign src_fast = fast[sel];

    assign hit_fast[k]           = usable && src_act && src_fast;
    assign hit_norm[k]           = usable && src_act && !src_fast;
    assign ids[k*ID_W +: ID_W]   = num;
  end
endmodule

// File: rtl/prs_first_pick.sv
module prs_first_pick
  import prs_pkg::*;
#(
  parameter int NSLOT = 40
) (
  input  logic [NSLOT-1:0]      hit,
  input  logic [NSLOT*ID_W-1:0] ids,
  output pick_t                 pick
);
  localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [IW-1:0] idx;
  logic          any;

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (hit[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end

  always_comb begin
    pick.found = any;
    pick.id    = any ? ids[idx*ID_W +: ID_W] : NONE_ID;
  end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prs_pkg::*;
#(
  parameter int NSRC  = 40,
  parameter int NSLOT = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NSRC-1:0]          src_pend,
  input  logic [NSRC-1:0]          src_en,
  input  logic [NSRC-1:0]          src_fast,
  input  logic [NSLOT*ENTRY_W-1:0] prio_tbl,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [31:0]              status
);
  logic [NSLOT-1:0]      q_fast, q_norm;
  logic [NSLOT*ID_W-1:0] q_ids;

  logic                  s1_v;
  logic [NSLOT-1:0]      s1_fast, s1_norm;
  logic [NSLOT*ID_W-1:0] s1_ids;

  logic                  s2_v;
  logic [31:0]           s2_word;
  logic                  s2_ready;

  pick_t                 p_fast, p_norm;

  assign s2_ready = !s2_v || out_ready;
  assign in_ready = !s1_v || s2_ready;

  prs_slot_qualify #(.NSRC(NSRC), .NSLOT(NSLOT)) u_qual (
    .pend     (src_pend),
    .en       (src_en),
    .fast     (src_fast),
    .tbl      (prio_tbl),
    .hit_fast (q_fast),
    .hit_norm (q_norm),
    .ids      (q_ids)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_fast <= '0;
      s1_norm <= '0;
      s1_ids  <= '0;
    end else if (in_ready) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_fast <= q_fast;
        s1_norm <= q_norm;
        s1_ids  <= q_ids;
      end
    end
  end

  prs_first_pick #(.NSLOT(NSLOT)) u_pick_fast (
    .hit  (s1_fast),
    .ids  (s1_ids),
    .pick (p_fast)
  );

  prs_first_pick #(.NSLOT(NSLOT)) u_pick_norm (
    .hit  (s1_norm),
    .ids  (s1_ids),
    .pick (p_norm)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v    <= 1'b0;
      s2_word <= '0;
    end else if (s2_ready) begin
      s2_v <= s1_v;
      if (s1_v) s2_word <= pack_word(p_fast, p_norm);
    end
  end

  assign out_valid = s2_v;
  assign status    = s2_word;
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
  parameter int NSRC = 40
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] status
);
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(status)); // R10
  AST_READY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready); // R10
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (status[30:22] == '0) && (status[14:6] == '0)); // R8
  AST_FAST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !status[15] |-> status[5:0] == 6'h3F); // R6
  AST_NORM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !status[31] |-> status[21:16] == 6'h3F); // R6
  AST_FAST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && status[15] |-> 32'(status[5:0]) < NSRC); // R4
  AST_NORM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && status[31] |-> 32'(status[21:16]) < NSRC); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R11
endmodule

bind prio_resolver prs_checker #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .status    (status)
);

// File: tb/prio_resolver_test.sv
module prio_resolver_test;
  localparam int NS = 40;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [NS-1:0]   src_pend = '0, src_en = '0, src_fast = '0;
  logic [NS*32-1:0] prio_tbl = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [31:0]     status;

  int checks = 0;
  int errors = 0;
  bit rand_ready = 1'b0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] tb_tbl [NS];

  always #2.5 clk = ~clk;

  prio_resolver uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_pend(src_pend), .src_en(src_en), .src_fast(src_fast),
    .prio_tbl(prio_tbl), .out_valid(out_valid), .out_ready(out_ready),
    .status(status)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scan model: walk slots from most to least urgent, first hit per class wins
  function automatic logic [31:0] model(logic [NS-1:0] p, logic [NS-1:0] e,
                                        logic [NS-1:0] f);
    logic fF = 0, fN = 0;
    logic [5:0] iF = 6'h3F, iN = 6'h3F;
    for (int k = 0; k < NS; k++) begin
      int s;
      s = int'(tb_tbl[k][5:0]);
      if (tb_tbl[k][31] && s < NS && p[s] && e[s]) begin
        if (f[s] && !fF) begin fF = 1; iF = tb_tbl[k][5:0]; end
        if (!f[s] && !fN) begin fN = 1; iN = tb_tbl[k][5:0]; end
      end
    end
    return {fN, 9'd0, iN, 16'd0} | {16'd0, fF, 9'd0, iF};
  endfunction

  task automatic send(string tag, logic [NS-1:0] p, logic [NS-1:0] e,
                      logic [NS-1:0] f);
    bit ok;
    @(negedge clk);
    src_pend = p; src_en = e; src_fast = f;
    for (int k = 0; k < NS; k++) prio_tbl[k*32 +: 32] = tb_tbl[k];
    in_valid = 1'b1;
    exp_q.push_back(model(p, e, f));
    tag_q.push_back(tag);
    do begin
      #1 ok = in_ready;
      @(posedge clk);
      if (!ok) @(negedge clk);
    end while (!ok);
    #0.5 in_valid = 1'b0;
  endtask

  task automatic clear_tbl();
    for (int k = 0; k < NS; k++) tb_tbl[k] = 32'h0;
  endtask

  always @(negedge clk) out_ready <= rand_ready ? ($urandom % 3 != 0) : 1'b1;

  // monitor: stall stability and scoreboard pops
  logic [31:0] held_w;
  bit held_v = 1'b0;
  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      if (held_v) check("R10 stalled word", status, held_w);
      check("R8 spare bits", status & 32'h7FC0_7FC0, 32'h0);
      if (out_ready) begin
        if (exp_q.size() == 0) begin
          errors++; checks++;
          $display("FAIL R9 extra word actual=%h expected=none", status);
        end else begin
          string t;
          t = tag_q.pop_front();
          check(t, status, exp_q.pop_front());
        end
        held_v = 1'b0;
      end else begin
        held_v = 1'b1; held_w = status;
      end
    end else held_v = 1'b0;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R11 out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R11 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R11 in_ready after reset", {31'd0, in_ready}, 32'd1);

    // R6: nothing qualifies
    clear_tbl();
    send("R6 empty", '0, '0, '0);
    // R9: latency with ready held high
    @(negedge clk); #2;
    check("R9 not yet valid", {31'd0, out_valid}, 32'd0);
    @(negedge clk); #2;
    check("R9 valid after one more edge", {31'd0, out_valid}, 32'd1);
    check("R6 word 003F003F", status, 32'h003F003F);

    // R1: disabled slot, out-of-range number, junk bits ignored
    clear_tbl();
    tb_tbl[0] = 32'h0000_0003;
    tb_tbl[1] = 32'h8000_002D;
    tb_tbl[5] = 32'h8123_4F03;
    send("R1 eligibility", 40'h8, 40'h8, 40'h0);
    // R2: masked and not-pending sources ignored, class bit routes
    clear_tbl();
    tb_tbl[0] = 32'h8000_0001; tb_tbl[1] = 32'h8000_0002;
    tb_tbl[2] = 32'h8000_0004; tb_tbl[3] = 32'h8000_0006;
    send("R2 qualify", 40'h16, 40'h54, 40'h40);
    // R3: lowest slot wins, duplicate slots
    clear_tbl();
    tb_tbl[0] = 32'h8000_0009; tb_tbl[1] = 32'h8000_0009;
    tb_tbl[2] = 32'h8000_0011; tb_tbl[7] = 32'h8000_0007;
    send("R3 lowest slot", 40'h20080, 40'h20080, 40'h0);
    // R4/R7: both classes at once
    clear_tbl();
    tb_tbl[10] = 32'h8000_0027; tb_tbl[20] = 32'h8000_0000;
    send("R7 both halves", 40'h80_0000_0001, '1, 40'h80_0000_0000);
    // R5: normal class from upper sources
    clear_tbl();
    tb_tbl[39] = 32'h8000_0021;
    send("R5 normal half", 40'h02_0000_0000, '1, '0);
    send("R4 fast half", 40'h02_0000_0000, '1, 40'h02_0000_0000);

    // random traffic with back-pressure
    rand_ready = 1'b1;
    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < NS; k++)
        tb_tbl[k] = {($urandom % 4 != 0), 25'($urandom), 6'($urandom)};
      send("R3/R7 random", {$urandom, $urandom}, {$urandom, $urandom},
           {$urandom, $urandom});
      if (n % 50 == 0) repeat (6) @(negedge clk);
    end
    rand_ready = 1'b0;
    repeat (20) @(negedge clk);
    check("R9 all words delivered", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule